// File: doc/BRIEF.md
# Daisy-Chain Bus Master Interface

This block is the master-side port of one function attached to a shared, multi-master bus. A local client asks for one transfer at a time. The block then raises the active-low request line for its priority level. It also takes part in the precedence chain that orders the functions sharing that level. An incoming precedence pulse is forwarded downstream one clock later, unless this function is requesting and its level is selected. In that case the pulse is trapped and the function has won the bus.

After it wins, the master acknowledges and drops its request. It then waits for the previous transfer's strobe to clear before it drives address, direction, width control and, for a write, data. It asserts strobe and releases acknowledge, and holds everything until the slave signals done. An arbiter that drops select before seeing acknowledge aborts the cycle. The master then goes back to idle and requests again. Arbitration and slave address decoding belong elsewhere.

Top module: `dcbm_master`

## Requirements
- R1: After reset, `bus_req_n`, `bus_ack_n`, `bus_strb_n`, `bus_write_n` and `bus_byte_n` are high, while `bus_oe`, `prec_out`, `bus_addr` and `bus_wdata` are zero.
- R2: With `cmd_valid` high, `bus_req_n` goes low one cycle after a clock edge at which the wired acknowledge `bus_ack_in_n` is high. While `bus_ack_in_n` is held low by another function, `bus_req_n` stays high.
- R3: A one-cycle high on `prec_in` appears on `prec_out` exactly one cycle later when the block is idle, or when it is requesting while `bus_sel_n` is high.
- R4: When the block is requesting and `bus_sel_n` is low, a pulse on `prec_in` is not forwarded. In the next cycle `bus_ack_n` is low and `bus_req_n` is high.
- R5: After acknowledging, `bus_oe` stays 0 while `bus_strb_in_n` is low. `bus_oe` becomes 1 one cycle after the first edge at which `bus_strb_in_n` is high, with `bus_strb_n` still high.
- R6: While driving, `bus_write_n` is low for a write and high for a read. `bus_wdata` is zero for a read.
- R7: For a word (`cmd_byte`=0), `bus_byte_n` is high and all data bits carry the write data. For a byte (`cmd_byte`=1), `bus_byte_n` is low, `bus_wdata[7:0]` carries the write data and the upper bits are zero. A byte read returns `bus_rdata[7:0]` with the upper bits of `cmd_rdata` zero.
- R8: One cycle after `bus_oe` rises, `bus_strb_n` goes low and `bus_ack_n` goes high. `bus_addr` stays stable while driving.
- R9: One cycle after an edge where `bus_strb_n` and `bus_done_n` are both low, `bus_strb_n`, `bus_write_n`, `bus_byte_n` and `bus_ack_n` are high and `bus_oe` is 0. In that same cycle `cmd_done` pulses high for one cycle, with `cmd_rdata` holding the captured read data.
- R10: If `bus_sel_n` goes low and then high again while requesting, with no precedence pulse, `bus_req_n` goes high for exactly one cycle and is then asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Transfer requested; held until `cmd_done` |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_byte | input | 1 | 1 = 8-bit byte, 0 = full word |
| cmd_addr | input | AW | Transfer address |
| cmd_wdata | input | DW | Write data |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | DW | Read data, valid with `cmd_done` |
| bus_req_n | output | 1 | Request for this function's level, active low |
| bus_sel_n | input | 1 | Arbiter select for this level, active low |
| prec_in | input | 1 | Precedence pulse from upstream |
| prec_out | output | 1 | Precedence pulse to downstream |
| bus_ack_n | output | 1 | Selection acknowledge driven by this block, active low |
| bus_ack_in_n | input | 1 | Wired acknowledge line as seen on the bus |
| bus_strb_n | output | 1 | Strobe driven by this block, active low |
| bus_strb_in_n | input | 1 | Wired strobe line as seen on the bus |
| bus_done_n | input | 1 | Slave completion, active low |
| bus_oe | output | 1 | Address/control/data drive enable |
| bus_addr | output | AW | Address driven while `bus_oe` |
| bus_wdata | output | DW | Write data driven while `bus_oe` |
| bus_rdata | input | DW | Read data from the slave |
| bus_write_n | output | 1 | Write direction, active low |
| bus_byte_n | output | 1 | Byte transfer, active low |

## Verification
The assertions rely on a well-behaved arbiter and slave. Select changes only while the block is requesting, a precedence pulse lasts one cycle, and done is asserted only while this block's strobe is low and is released once strobe rises. The bench's bus model follows these rules. It drives every bus input on the falling edge, pulses precedence only after select is settled, and holds done until it sees the strobe released. It also holds the external strobe and acknowledge lines low for stretches, to stand in for other masters.

// File: rtl/dcbm_pkg.sv
package dcbm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_ACK   = 3'd2,
      ST_DRIVE = 3'd3,
      ST_STRB  = 3'd4
   } dcbm_state_e;
endpackage

// File: rtl/dcbm_chain.sv
module dcbm_chain (
   input  logic clk,
   input  logic rst_n,
   input  logic prec_in,
   input  logic trap,
   output logic prec_out
);
   logic prec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prec_q <= 1'b0;
      else        prec_q <= prec_in & ~trap;
   end

   assign prec_out = prec_q;

   AST_PASS_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      prec_out |-> $past(prec_in)); // R3
endmodule

// File: rtl/dcbm_seq.sv
module dcbm_seq
   import dcbm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic        prec_in,
   input  logic        sel_n,
   input  logic        ack_in_n,
   input  logic        strb_in_n,
   input  logic        done_n,
   output dcbm_state_e state,
   output logic        trap,
   output logic        load,
   output logic        capture,
   output logic        done_pulse
);
   dcbm_state_e st_q, st_d;
   logic        sel_seen_q;
   logic        done_q;

   assign trap    = (st_q == ST_REQ) && prec_in && !sel_n;
   assign load    = (st_q == ST_IDLE) && (st_d == ST_REQ);
   assign capture = (st_q == ST_STRB) && !done_n;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (cmd_valid && ack_in_n) st_d = ST_REQ;
         ST_REQ: begin
            if (trap)                   st_d = ST_ACK;
            else if (sel_seen_q && sel_n) st_d = ST_IDLE;
         end
         ST_ACK:   if (strb_in_n) st_d = ST_DRIVE;
         ST_DRIVE: st_d = ST_STRB;
         ST_STRB:  if (!done_n) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         sel_seen_q <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         st_q       <= st_d;
         sel_seen_q <= (st_q == ST_REQ) && st_d == ST_REQ && (sel_seen_q || !sel_n);
         done_q     <= capture;
      end
   end

   assign state      = st_q;
   assign done_pulse = done_q;

   AST_ABORT_ONLY_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && $past(st_q) == ST_REQ) |-> ($past(sel_seen_q) && $past(sel_n))); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R9
endmodule

// File: rtl/dcbm_datapath.sv
module dcbm_datapath #(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          drive,
   input  logic          capture,
   input  logic          cmd_write,
   input  logic          cmd_byte,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_write_n,
   output logic          bus_byte_n,
   output logic [DW-1:0] rdata
);
   localparam int NLANES = DW / BW;

   if (AW < 1)           begin : g_bad_aw  $error("AW must be positive");          end
   if (BW < 1 || DW < BW) begin : g_bad_bw  $error("BW must be 1..DW");             end
   if (DW % BW != 0)     begin : g_bad_div $error("DW must be a multiple of BW");  end

   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          write_q;
   logic          byte_q;
   logic [DW-1:0] rdata_q;
   logic [DW-1:0] lane_mask;

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      if (g == 0) begin : g_low
         assign lane_mask[g*BW +: BW] = '1;
      end else begin : g_high
         assign lane_mask[g*BW +: BW] = {BW{~byte_q}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         byte_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (load) begin
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            write_q <= cmd_write;
            byte_q  <= cmd_byte;
         end
         if (capture) rdata_q <= bus_rdata & lane_mask;
      end
   end

   assign bus_addr    = drive ? addr_q : '0;
   assign bus_wdata   = (drive && write_q) ? (wdata_q & lane_mask) : '0;
   assign bus_write_n = ~(drive && write_q);
   assign bus_byte_n  = ~(drive && byte_q);
   assign rdata       = rdata_q;

   AST_BYTE_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_byte_n) |-> (bus_wdata[DW-1:BW] == '0)); // R7
   AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_write_n) |-> (bus_wdata == '0)); // R6
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && $past(drive)) |-> $stable(bus_addr)); // R8
endmodule

// File: rtl/dcbm_master.sv
module dcbm_master
   import dcbm_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic          cmd_write,
   input  logic          cmd_byte,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   output logic          cmd_done,
   output logic [DW-1:0] cmd_rdata,
   output logic          bus_req_n,
   input  logic          bus_sel_n,
   input  logic          prec_in,
   output logic          prec_out,
   output logic          bus_ack_n,
   input  logic          bus_ack_in_n,
   output logic          bus_strb_n,
   input  logic          bus_strb_in_n,
   input  logic          bus_done_n,
   output logic          bus_oe,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          bus_write_n,
   output logic          bus_byte_n
);
   dcbm_state_e state;
   logic trap, load, capture, drive;

   dcbm_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .prec_in    (prec_in),
      .sel_n      (bus_sel_n),
      .ack_in_n   (bus_ack_in_n),
      .strb_in_n  (bus_strb_in_n),
      .done_n     (bus_done_n),
      .state      (state),
      .trap       (trap),
      .load       (load),
      .capture    (capture),
      .done_pulse (cmd_done)
   );

   dcbm_chain u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .prec_in  (prec_in),
      .trap     (trap),
      .prec_out (prec_out)
   );

   assign drive = (state == ST_DRIVE) || (state == ST_STRB);

   dcbm_datapath #(.AW(AW), .DW(DW), .BW(BW)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .drive       (drive),
      .capture     (capture),
      .cmd_write   (cmd_write),
      .cmd_byte    (cmd_byte),
      .cmd_addr    (cmd_addr),
      .cmd_wdata   (cmd_wdata),
      .bus_rdata   (bus_rdata),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_write_n (bus_write_n),
      .bus_byte_n  (bus_byte_n),
      .rdata       (cmd_rdata)
   );

   assign bus_req_n  = ~(state == ST_REQ);
   assign bus_ack_n  = ~((state == ST_ACK) || (state == ST_DRIVE));
   assign bus_strb_n = ~(state == ST_STRB);
   assign bus_oe     = drive;

   AST_REQ_WAITS_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req_n) |-> $past(bus_ack_in_n)); // R2
   AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ack_n) |-> bus_req_n); // R4
   AST_WIN_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ack_n && $past(bus_ack_n)) |-> !prec_out); // R4
   AST_DRIVE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> $past(bus_strb_in_n)); // R5
   AST_STRB_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_strb_n) |-> (bus_ack_n && bus_oe)); // R8
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!bus_strb_n && !bus_done_n) |-> (bus_strb_n && !bus_oe && cmd_done)); // R9
endmodule

// File: tb/dcbm_master_bench.sv
`timescale 1ns/1ps
module dcbm_master_bench;
   localparam int AW = 16;
   localparam int DW = 16;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic          write;
      logic          byte_m;
      logic [DW-1:0] wdata;
      logic [DW-1:0] slave;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_byte = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic cmd_done;
   logic [DW-1:0] cmd_rdata;
   logic bus_req_n, prec_out, bus_ack_n, bus_strb_n, bus_oe, bus_write_n, bus_byte_n;
   logic bus_sel_n = 1'b1, prec_in = 1'b0, bus_done_n = 1'b1;
   logic ext_ack_n = 1'b1, ext_strb_n = 1'b1;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   item_t sb_q[$];

   always #2.5 clk = ~clk;

   dcbm_master #(.AW(AW), .DW(DW), .BW(8)) u_dcbm_master (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_byte(cmd_byte),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
      .bus_req_n(bus_req_n), .bus_sel_n(bus_sel_n),
      .prec_in(prec_in), .prec_out(prec_out),
      .bus_ack_n(bus_ack_n), .bus_ack_in_n(bus_ack_n & ext_ack_n),
      .bus_strb_n(bus_strb_n), .bus_strb_in_n(bus_strb_n & ext_strb_n),
      .bus_done_n(bus_done_n), .bus_oe(bus_oe),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_write_n(bus_write_n), .bus_byte_n(bus_byte_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor and slave model: compare driven transfer with scoreboard, answer done
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !bus_strb_n) begin
            item_t it;
            if (sb_q.size() == 0) begin
               chk("R8 strobe without expected item", 32'd1, 32'd0);
            end else begin
               it = sb_q.pop_front();
               chk("R8 address", 32'(bus_addr), 32'(it.addr));
               chk("R6 write line", 32'(bus_write_n), 32'(!it.write));
               chk("R7 byte line", 32'(bus_byte_n), 32'(!it.byte_m));
               chk("R7 write data", 32'(bus_wdata),
                   it.write ? (it.byte_m ? 32'(it.wdata[7:0]) : 32'(it.wdata)) : 32'd0);
               bus_rdata = it.slave;
            end
            @(negedge clk);
            bus_done_n = 1'b0;
            @(negedge clk);
            bus_done_n = 1'b1;
         end
      end
   end

   task automatic start_cmd(input logic [AW-1:0] a, input logic w, input logic b,
                            input logic [DW-1:0] wd, input logic [DW-1:0] sd, input int block);
      item_t it;
      it = '{addr: a, write: w, byte_m: b, wdata: wd, slave: sd};
      sb_q.push_back(it);
      @(negedge clk);
      cmd_addr = a; cmd_write = w; cmd_byte = b; cmd_wdata = wd; cmd_valid = 1'b1;
      if (block > 0) ext_ack_n = 1'b0;
      for (int i = 0; i < block; i++) begin
         @(negedge clk);
         chk("R2 request held off by acknowledge", 32'(bus_req_n), 32'd1);
      end
      ext_ack_n = 1'b1;
      @(negedge clk);
      chk("R2 request asserted", 32'(bus_req_n), 32'd0);
   endtask

   task automatic finish_cmd(input int hold);
      logic [DW-1:0] exp_rd;
      item_t it;
      int n;
      it = sb_q[0];
      exp_rd = it.write ? cmd_rdata : (it.byte_m ? {8'h00, it.slave[7:0]} : it.slave);
      bus_sel_n = 1'b0;
      if (hold > 0) ext_strb_n = 1'b0;
      @(negedge clk);
      prec_in = 1'b1;
      @(negedge clk);
      prec_in = 1'b0;
      bus_sel_n = 1'b1;
      chk("R4 acknowledge asserted", 32'(bus_ack_n), 32'd0);
      chk("R4 request removed", 32'(bus_req_n), 32'd1);
      chk("R4 pulse trapped", 32'(prec_out), 32'd0);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk("R5 no drive while strobe busy", 32'(bus_oe), 32'd0);
      end
      ext_strb_n = 1'b1;
      @(negedge clk);
      chk("R5 drive after strobe clear", 32'(bus_oe), 32'd1);
      chk("R5 strobe not yet", 32'(bus_strb_n), 32'd1);
      @(negedge clk);
      chk("R8 strobe asserted", 32'(bus_strb_n), 32'd0);
      chk("R8 acknowledge released", 32'(bus_ack_n), 32'd1);
      n = 0;
      while (!cmd_done && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk("R9 done pulse", 32'(cmd_done), 32'd1);
      if (!it.write) chk("R7 read data", 32'(cmd_rdata), 32'(exp_rd));
      chk("R9 strobe released", 32'(bus_strb_n), 32'd1);
      chk("R9 drive released", 32'(bus_oe), 32'd0);
      chk("R9 controls released", 32'({bus_write_n, bus_byte_n, bus_ack_n}), 32'h7);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk("R9 done single cycle", 32'(cmd_done), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 bus controls idle", 32'({bus_req_n, bus_ack_n, bus_strb_n, bus_write_n, bus_byte_n}), 32'h1f);
      chk("R1 drive and chain idle", 32'({bus_oe, prec_out}), 32'd0);
      chk("R1 bus address and data", 32'({bus_addr, bus_wdata}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 pass-through while idle
      prec_in = 1'b1;
      @(negedge clk);
      prec_in = 1'b0;
      chk("R3 idle pass-through", 32'(prec_out), 32'd1);
      @(negedge clk);
      chk("R3 pulse one cycle", 32'(prec_out), 32'd0);

      // word write, no strobe wait
      start_cmd(16'h1234, 1'b1, 1'b0, 16'hBEEF, 16'h0000, 0);
      finish_cmd(0);
      // word read with previous strobe held
      start_cmd(16'hA5A5, 1'b0, 1'b0, 16'h0000, 16'hC3D2, 0);
      finish_cmd(3);
      // byte write, request blocked by another acknowledge
      start_cmd(16'h00FF, 1'b1, 1'b1, 16'h77AB, 16'h0000, 4);
      finish_cmd(1);
      // byte read: pass while unselected, then abort and retry
      start_cmd(16'h8001, 1'b0, 1'b1, 16'h0000, 16'h9E5C, 0);
      prec_in = 1'b1;
      @(negedge clk);
      prec_in = 1'b0;
      chk("R3 pass while level unselected", 32'(prec_out), 32'd1);
      chk("R3 still requesting", 32'(bus_req_n), 32'd0);
      bus_sel_n = 1'b0;
      @(negedge clk);
      bus_sel_n = 1'b1;
      @(negedge clk);
      chk("R10 request dropped on abort", 32'(bus_req_n), 32'd1);
      @(negedge clk);
      chk("R10 request raised again", 32'(bus_req_n), 32'd0);
      finish_cmd(0);

      chk("R8 scoreboard drained", 32'(sb_q.size()), 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule